// File: doc/BRIEF.md
# Output-Compare Timer with Register Bus

This block is a general-purpose up-counter for scheduling one-shot or periodic events. Software reaches it over a small memory-mapped bus with 32-bit words, a write strobe and a read strobe. It configures a clock source, a divider and a compare value. When the counter reaches the compare value, a sticky status flag is set. That flag, gated by an enable bit, drives one level-sensitive interrupt line.

Everything runs on one clock. Each of the three possible count sources arrives as a one-cycle tick-enable pulse that is synchronous to that clock. The counter either runs freely through its full range, or returns to zero after it matches, which gives a periodic event. A self-clearing software reset returns every register to its reset value. Software can poll the reset bit to see when the reset is done.

Top module: `ocmp_timer`

## Requirements
- R1: After `rst_n` is low, every readable register reads 0 and `irq` is 0.
- R2: The register offsets are: control 0x00, divider 0x04, compare 0x08, capture 0x0C, counter 0x10 and status 0x14. The capture offset and any unmapped offset read 0. Writes to capture and to the counter have no effect. `bus_rdata` is 0 when `bus_rd` is low.
- R3: Control bits 3:1 select the count source: 0 = none, 1 = `tick_hf`, 3 = `tick_ext`, 4 = `tick_32k`, and any other code = none. Ticks on sources that are not selected have no effect. Control bits 0, 3:1, 4 and 8 read back as written, and all other control bits read 0 when no reset is in progress.
- R4: The divider register holds N-1. With control bit 0 set, the counter advances once on every Nth selected tick. The new value is readable in the cycle after that tick.
- R5: With control bit 8 set (free-run), the counter continues past a compare match and wraps from its all-ones value to 0.
- R6: With control bit 8 clear (restart), an advance from a value equal to the compare register loads 0.
- R7: Status bit 0 is set when the counter advances to a value equal to the compare register. Writing 1 to status bit 0 clears it. Writing 0 there has no effect.
- R8: When a set event and a write-one-to-clear of status bit 0 happen in the same cycle, the flag ends up set.
- R9: `irq` is high exactly while status bit 0 is set and control bit 4 is 1. Clearing either of them drops `irq`.
- R10: While control bit 0 is 0, the counter and the divider phase hold their values and are not reset. Counting resumes from the held phase.
- R11: Writing 1 to control bit 15 returns all registers to reset values. Control bit 15 then reads 1 for the next 4 cycles and 0 afterwards. Bus writes during those cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the accessed register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tick_hf | input | 1 | High-frequency peripheral tick enable |
| tick_ext | input | 1 | External clock-in tick enable |
| tick_32k | input | 1 | Slow 32 kHz tick enable |
| irq | output | 1 | Level compare interrupt |

## Verification
The hidden state consists of the divider phase, the counter and the flag. A wrong divider phase shows up as a counter read that comes one or more source ticks early or late. This becomes visible at the first advance after the disturbance, so the bench reads the counter right after the exact tick counts at which it should change. A flag with the wrong priority, or a restart that loads the wrong value, shows up in the status or counter read in the cycle right after the matching tick. Errors in the soft-reset sequence show in the control read on the cycles after the reset write, because the busy bit must drop after exactly four cycles.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

   localparam int unsigned OFF_CTRL  = 'h00;
   localparam int unsigned OFF_DIV   = 'h04;
   localparam int unsigned OFF_CMP   = 'h08;
   localparam int unsigned OFF_CAPT  = 'h0C;
   localparam int unsigned OFF_COUNT = 'h10;
   localparam int unsigned OFF_STAT  = 'h14;

   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_HF   = 3'd1,
      SRC_EXT  = 3'd3,
      SRC_SLOW = 3'd4
   } src_sel_e;

   // picks the active tick for the encoded source field
   function automatic logic pick_tick(input logic [2:0] sel, input logic hf,
                                      input logic ext, input logic slow);
      logic r;
      case (sel)
         SRC_HF:   r = hf;
         SRC_EXT:  r = ext;
         SRC_SLOW: r = slow;
         default:  r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs #(
   parameter int ADDR_W     = 5,
   parameter int CNT_W      = 32,
   parameter int DIV_W      = 12,
   parameter int SWR_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic              ctrl_en,
   output logic [2:0]        ctrl_src,
   output logic              ctrl_ie,
   output logic              ctrl_fr,
   output logic [DIV_W-1:0]  div_q,
   output logic [CNT_W-1:0]  cmp_q,
   output logic              swr_start,
   output logic              swr_busy,
   output logic              flag_clr
);
   import ocmp_pkg::*;

   localparam int SW_CW = $clog2(SWR_CYCLES + 1);

   logic [SW_CW-1:0] swr_cnt;
   logic             wr_ok;
   logic             hit_ctrl, hit_div, hit_cmp, hit_stat;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata;

   assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
   assign hit_div  = (bus_addr == ADDR_W'(OFF_DIV));
   assign hit_cmp  = (bus_addr == ADDR_W'(OFF_CMP));
   assign hit_stat = (bus_addr == ADDR_W'(OFF_STAT));

   assign swr_busy  = (swr_cnt != '0);
   assign wr_ok     = bus_wr && !swr_busy;
   assign swr_start = wr_ok && hit_ctrl && bus_wdata[15];
   assign flag_clr  = wr_ok && hit_stat && bus_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_en  <= 1'b0;
         ctrl_src <= 3'd0;
         ctrl_ie  <= 1'b0;
         ctrl_fr  <= 1'b0;
         div_q    <= '0;
         cmp_q    <= '0;
         swr_cnt  <= '0;
      end else if (swr_start) begin
         ctrl_en  <= 1'b0;
         ctrl_src <= 3'd0;
         ctrl_ie  <= 1'b0;
         ctrl_fr  <= 1'b0;
         div_q    <= '0;
         cmp_q    <= '0;
         swr_cnt  <= SW_CW'(SWR_CYCLES);
      end else begin
         if (swr_busy) swr_cnt <= swr_cnt - 1'b1;
         if (wr_ok && hit_ctrl) begin
            ctrl_en  <= bus_wdata[0];
            ctrl_src <= bus_wdata[3:1];
            ctrl_ie  <= bus_wdata[4];
            ctrl_fr  <= bus_wdata[8];
         end
         if (wr_ok && hit_div) div_q <= bus_wdata[DIV_W-1:0];
         if (wr_ok && hit_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/ocmp_prescale.sv
module ocmp_prescale #(
   parameter int DIV_W   = 12,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick_in,
   input  logic             en,
   input  logic [DIV_W-1:0] div_q,
   output logic             adv
);

   generate
      if (HAS_DIV) begin : g_div
         logic [DIV_W-1:0] phase_q;
         logic             wrap;

         assign wrap = (phase_q >= div_q);
         assign adv  = tick_in && en && wrap;

         always_ff @(posedge clk) begin
            if (!rst_n || clr)       phase_q <= '0;
            else if (tick_in && en)  phase_q <= wrap ? '0 : phase_q + 1'b1;
         end
      end else begin : g_bypass
         logic unused_div;
         logic unused_clk;
         assign unused_div = ^div_q;
         assign unused_clk = clk ^ rst_n ^ clr;
         assign adv        = tick_in && en;
      end
   endgenerate

endmodule

// File: rtl/ocmp_count.sv
module ocmp_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic             freerun,
   input  logic [CNT_W-1:0] cmp_q,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             flag_q
);
   logic [CNT_W-1:0] cnt_nxt;
   logic             hit;

   assign cnt_nxt = (!freerun && cnt_q == cmp_q) ? '0 : cnt_q + 1'b1;
   assign hit     = adv && (cnt_nxt == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (adv) cnt_q <= cnt_nxt;
         if (hit)           flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer #(
   parameter int ADDR_W     = 5,
   parameter int CNT_W      = 32,
   parameter int DIV_W      = 12,
   parameter bit HAS_DIV    = 1'b1,
   parameter int SWR_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              tick_hf,
   input  logic              tick_ext,
   input  logic              tick_32k,
   output logic              irq
);
   import ocmp_pkg::*;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("ocmp_timer: CNT_W must be 1..32");
      end
      if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
         $error("ocmp_timer: DIV_W must be 1..32");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ocmp_timer: ADDR_W must reach offset 0x14");
      end
      if (SWR_CYCLES < 1) begin : g_bad_swr
         $error("ocmp_timer: SWR_CYCLES must be at least 1");
      end
   endgenerate

   logic             ctrl_en, ctrl_ie, ctrl_fr;
   logic [2:0]       ctrl_src;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] cmp_q, cnt_q;
   logic             swr_start, swr_busy, soft_clr, flag_clr, flag_q;
   logic             tick_sel, adv;
   logic [31:0]      cnt_ext, cmp_ext, div_ext, ctrl_word;

   ocmp_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .SWR_CYCLES(SWR_CYCLES)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .ctrl_en(ctrl_en), .ctrl_src(ctrl_src),
      .ctrl_ie(ctrl_ie), .ctrl_fr(ctrl_fr), .div_q(div_q), .cmp_q(cmp_q),
      .swr_start(swr_start), .swr_busy(swr_busy), .flag_clr(flag_clr)
   );

   assign soft_clr = swr_start | swr_busy;
   assign tick_sel = pick_tick(ctrl_src, tick_hf, tick_ext, tick_32k);

   ocmp_prescale #(.DIV_W(DIV_W), .HAS_DIV(HAS_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr), .tick_in(tick_sel),
      .en(ctrl_en), .div_q(div_q), .adv(adv)
   );

   ocmp_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr), .adv(adv),
      .freerun(ctrl_fr), .cmp_q(cmp_q), .flag_clr(flag_clr),
      .cnt_q(cnt_q), .flag_q(flag_q)
   );

   always_comb begin
      cnt_ext = '0;
      cnt_ext[CNT_W-1:0] = cnt_q;
      cmp_ext = '0;
      cmp_ext[CNT_W-1:0] = cmp_q;
      div_ext = '0;
      div_ext[DIV_W-1:0] = div_q;
   end

   assign ctrl_word = {16'd0, swr_busy, 6'd0, ctrl_fr, 3'd0, ctrl_ie, ctrl_src, ctrl_en};

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            ADDR_W'(OFF_CTRL):  bus_rdata = ctrl_word;
            ADDR_W'(OFF_DIV):   bus_rdata = div_ext;
            ADDR_W'(OFF_CMP):   bus_rdata = cmp_ext;
            ADDR_W'(OFF_COUNT): bus_rdata = cnt_ext;
            ADDR_W'(OFF_STAT):  bus_rdata = {31'd0, flag_q};
            default:            bus_rdata = '0;
         endcase
      end
   end

   assign irq = flag_q & ctrl_ie;

endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             swr_start,
   input logic             swr_busy,
   input logic             ctrl_en,
   input logic             ctrl_fr,
   input logic             tick_sel,
   input logic             adv,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] cmp_q,
   input logic             flag_q
);

   // R11
   swr_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swr_busy |-> (cnt_q == '0 && !flag_q && !ctrl_en));

   // R10
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && !swr_start) |=> $stable(cnt_q));

   // R6
   restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ctrl_fr && cnt_q == cmp_q && !swr_start) |=> (cnt_q == '0));

   // R7
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> (cnt_q == $past(cmp_q)));

   // R4
   step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt_q) && !$past(swr_start)) |-> $past(tick_sel && ctrl_en));

endmodule

bind ocmp_timer ocmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .swr_start(swr_start), .swr_busy(swr_busy),
   .ctrl_en(ctrl_en), .ctrl_fr(ctrl_fr), .tick_sel(tick_sel), .adv(adv),
   .cnt_q(cnt_q), .cmp_q(cmp_q), .flag_q(flag_q)
);

// File: tb/ocmp_timer_tb.sv
module ocmp_timer_tb;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata, rdata_n;
   logic        tick_hf = 1'b0, tick_ext = 1'b0, tick_32k = 1'b0;
   logic        irq, irq_n;
   int          n_chk = 0;
   int          n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   ocmp_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata),
      .tick_hf(tick_hf), .tick_ext(tick_ext), .tick_32k(tick_32k), .irq(irq)
   );

   ocmp_timer #(.CNT_W(8)) u_dut_narrow (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
      .tick_hf(tick_hf), .tick_ext(tick_ext), .tick_32k(tick_32k), .irq(irq_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // all tasks start just after a falling edge and end one falling edge later
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      chk(req, rdata, exp);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_narrow(input logic [4:0] a, input logic [31:0] exp, input string req);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      chk(req, rdata_n, exp);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // m: bit0 hf, bit1 ext, bit2 32k
   task automatic pulse(input logic [2:0] m, input int n);
      for (int i = 0; i < n; i++) begin
         {tick_32k, tick_ext, tick_hf} = m;
         @(negedge clk);
      end
      {tick_32k, tick_ext, tick_hf} = 3'b000;
   endtask

   task automatic soft_reset();
      wr(5'h00, 32'h0000_8000);
      repeat (5) @(negedge clk);
   endtask

   task automatic t_reset();
      rd(5'h00, 0, "R1 ctrl");
      rd(5'h04, 0, "R1 divider");
      rd(5'h08, 0, "R1 compare");
      rd(5'h10, 0, "R1 counter");
      rd(5'h14, 0, "R1 status");
      chk("R1 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_map();
      wr(5'h04, 32'd3);
      wr(5'h08, 32'h55);
      wr(5'h0C, 32'hFFFF_FFFF);
      wr(5'h10, 32'h1234);
      rd(5'h04, 32'd3, "R2 divider");
      rd(5'h08, 32'h55, "R2 compare");
      rd(5'h0C, 0, "R2 capture");
      rd(5'h10, 0, "R2 counter write ignored");
      rd(5'h18, 0, "R2 unmapped");
      bus_addr = 5'h08; #1;
      chk("R2 no read strobe", rdata, 0);
      @(negedge clk);
      wr(5'h00, 32'hFFFF_7FFF);
      rd(5'h00, 32'h0000_011F, "R3 ctrl readback");
      wr(5'h00, 0);
   endtask

   task automatic t_sources();
      wr(5'h04, 0);
      wr(5'h00, 32'h103);
      pulse(3'b001, 5);
      rd(5'h10, 5, "R3 hf counts");
      pulse(3'b110, 3);
      rd(5'h10, 5, "R3 others ignored for hf");
      wr(5'h00, 32'h107);
      pulse(3'b010, 2);
      rd(5'h10, 7, "R3 ext counts");
      pulse(3'b101, 2);
      rd(5'h10, 7, "R3 others ignored for ext");
      wr(5'h00, 32'h109);
      pulse(3'b100, 3);
      rd(5'h10, 10, "R3 32k counts");
      pulse(3'b011, 3);
      rd(5'h10, 10, "R3 others ignored for 32k");
      wr(5'h00, 32'h101);
      pulse(3'b111, 4);
      rd(5'h10, 10, "R3 source none");
      wr(5'h00, 32'h105);
      pulse(3'b111, 4);
      rd(5'h10, 10, "R3 unused code");
   endtask

   task automatic t_divider();
      soft_reset();
      wr(5'h04, 32'd2);
      wr(5'h00, 32'h103);
      pulse(3'b001, 2);
      rd(5'h10, 0, "R4 before third tick");
      pulse(3'b001, 1);
      rd(5'h10, 1, "R4 third tick");
      pulse(3'b001, 6);
      rd(5'h10, 3, "R4 divide by three");
   endtask

   task automatic t_hold();
      pulse(3'b001, 1);
      wr(5'h00, 32'h102);
      pulse(3'b001, 5);
      rd(5'h10, 3, "R10 counter held");
      wr(5'h00, 32'h103);
      pulse(3'b001, 1);
      rd(5'h10, 3, "R10 phase kept, one short");
      pulse(3'b001, 1);
      rd(5'h10, 4, "R10 phase kept, advance");
   endtask

   task automatic t_compare();
      soft_reset();
      wr(5'h08, 32'd5);
      wr(5'h00, 32'h113);
      pulse(3'b001, 4);
      rd(5'h14, 0, "R7 no match yet");
      chk("R9 irq low", {31'd0, irq}, 0);
      pulse(3'b001, 1);
      rd(5'h14, 1, "R7 match sets flag");
      chk("R9 irq high", {31'd0, irq}, 1);
      wr(5'h00, 32'h103);
      chk("R9 irq off with enable clear", {31'd0, irq}, 0);
      rd(5'h14, 1, "R9 flag kept");
      wr(5'h00, 32'h113);
      chk("R9 irq back", {31'd0, irq}, 1);
      wr(5'h14, 32'hFFFF_FFFE);
      rd(5'h14, 1, "R7 write zero no effect");
      wr(5'h14, 32'h1);
      rd(5'h14, 0, "R7 write one clears");
      chk("R9 irq low after clear", {31'd0, irq}, 0);
      pulse(3'b001, 3);
      rd(5'h10, 8, "R5 counts past match");
   endtask

   task automatic t_restart();
      soft_reset();
      wr(5'h08, 32'd3);
      wr(5'h00, 32'h013);
      pulse(3'b001, 3);
      rd(5'h14, 1, "R6 match flag");
      wr(5'h14, 32'h1);
      pulse(3'b001, 1);
      rd(5'h10, 0, "R6 reload zero");
      rd(5'h14, 0, "R6 no flag on reload");
      pulse(3'b001, 3);
      rd(5'h10, 3, "R6 second period");
      rd(5'h14, 1, "R6 second match");
   endtask

   task automatic t_collide();
      soft_reset();
      wr(5'h08, 32'd2);
      wr(5'h00, 32'h103);
      pulse(3'b001, 1);
      tick_hf = 1'b1;
      wr(5'h14, 32'h1);
      tick_hf = 1'b0;
      rd(5'h14, 1, "R8 set beats clear");
      rd(5'h10, 2, "R8 counter at match");
   endtask

   task automatic t_wrap();
      soft_reset();
      wr(5'h08, 32'h10);
      wr(5'h00, 32'h103);
      pulse(3'b001, 255);
      rd_narrow(5'h10, 32'hFF, "R5 narrow at top");
      pulse(3'b001, 1);
      rd_narrow(5'h10, 0, "R5 narrow wraps");
      rd(5'h10, 256, "R5 wide no wrap");
   endtask

   task automatic t_swr();
      wr(5'h04, 32'd7);
      wr(5'h08, 32'd9);
      wr(5'h00, 32'h8113);
      rd(5'h00, 32'h8000, "R11 busy 1");
      wr(5'h04, 32'd5);
      rd(5'h00, 32'h8000, "R11 busy 3");
      rd(5'h00, 32'h8000, "R11 busy 4");
      rd(5'h00, 0, "R11 busy clears");
      rd(5'h04, 0, "R11 divider reset, write ignored");
      rd(5'h08, 0, "R11 compare reset");
      rd(5'h10, 0, "R11 counter reset");
      rd(5'h14, 0, "R11 status reset");
      chk("R11 irq low", {31'd0, irq}, 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_sources();
      t_divider();
      t_hold();
      t_compare();
      t_restart();
      t_collide();
      t_wrap();
      t_swr();
      finish_run();
   end

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

endmodule